// File: doc/BRIEF.md
# Shadowed Configuration Register Bank

This block keeps a small set of configuration bytes in two copies. One copy is a bank of working registers that the bus can write. The other is a one-time-programmable store, modelled here as a register array that a program strobe loads. A command register holds one select bit per byte. Each select bit chooses which copy drives that byte's configuration output and which copy a bus read at that byte's address returns. The command register also holds a programming request bit, a soft-clear bit and a switch-off bit.

The command register clears on power-up reset and whenever the shutdown/fault input is high. Clearing it drops every select bit, so the configuration falls back to the programmed store. The working registers have no reset. To make a new setting permanent, the user writes the working bytes, applies the programming voltage and sets the program bit. The working image is then copied into the store once the store reports that it is not busy. A lock bit inside the programmed store blocks every later change to the configuration. After lock, only the switch-off and soft-clear command bits still act.

Top module: `cfg_shadow_bank`

## Requirements
- R1: After power-up reset the command register reads 00h, the switch-off output is 0, and every configuration byte equals the programmed store, which starts blank (00h).
- R2: A write to address i (0 to NBYTES-1) always updates working byte i. A read of address i returns working byte i when select bit i (command bit i) is 1 and store byte i when it is 0. With rd_en high at a clock edge, rd_data carries the byte from that edge onward.
- R3: Configuration byte i on cfg_o (bits i*8+7 down to i*8) equals working byte i when select bit i is 1 and store byte i when it is 0. It changes at the edge that updates the select bit or the chosen byte.
- R4: The command register sits at address NBYTES (3). A read of any address above 3 returns 00h. A write there changes no byte, no command bit and no output.
- R5: While fault_i is high at a clock edge, the command register clears to 00h. The working bytes keep their contents.
- R6: Writing command bit 3 (program) as 1 while vpp_i is high sets that bit, and it reads back as 1 while otp_busy_i is high. At the first edge with otp_busy_i low, the store takes the working bytes and the bit clears.
- R7: A program write while vpp_i is low has no effect. The program bit reads 0 and the store is unchanged.
- R8: When bit 7 of store byte 0 (lock) is 1, the following are ignored: writes to the working bytes, changes to the select bits, and program requests. Command bit 5 (switch-off, driven on swoff_o) can still be written.
- R9: Writing the command register with bit 4 (soft clear) set clears the command register to 00h, including switch-off, whether or not the bank is locked. Bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-up reset |
| fault_i | input | 1 | Shutdown / lockout; clears the command register |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Byte read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| vpp_i | input | 1 | Programming voltage present |
| otp_busy_i | input | 1 | Store busy; holds a pending program |
| cfg_o | output | 24 | Active configuration bytes, byte 0 lowest |
| swoff_o | output | 1 | Switch-off command bit |

## Verification
A write takes effect at the clock edge that samples it, so cfg_o, swoff_o and the command readback are checked at the falling edge after the write's rising edge. A read is registered, and the bench samples rd_data at the falling edge after the edge that saw rd_en. A program request completes at the first rising edge with otp_busy_i low. The bench holds busy high through one readback, then releases it and samples one edge later. All stimulus changes on falling edges, so no sample shares an edge with a change of its input.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;
   // command bit offsets counted above the select field
   localparam int CMD_PROG_OFS  = 0;
   localparam int CMD_CLR_OFS   = 1;
   localparam int CMD_SWOFF_OFS = 2;
   localparam int CMD_EXTRA     = 3;
endpackage

// File: rtl/cfg_otp_store.sv
module cfg_otp_store #(
   parameter int NBYTES = 3,
   parameter int DW     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 prog_stb,
   input  logic [NBYTES*DW-1:0] wr_image,
   output logic [NBYTES*DW-1:0] rd_image
);
   localparam int TOTAL = NBYTES * DW;

   logic [TOTAL-1:0] mem_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mem_q <= '0;
      else if (prog_stb)
         mem_q <= wr_image;
   end

   assign rd_image = mem_q;

   // R6
   otp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_stb |=> $stable(mem_q));

   // R6
   otp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prog_stb |=> (mem_q == $past(wr_image)));
endmodule

// File: rtl/cfg_cmd_reg.sv
module cfg_cmd_reg
   import cfgbank_pkg::*;
#(
   parameter int NBYTES = 3,
   parameter int DW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fault_i,
   input  logic              wr_cmd,
   input  logic [DW-1:0]     wr_data,
   input  logic              locked,
   input  logic              vpp_i,
   input  logic              otp_busy_i,
   output logic [NBYTES-1:0] sel,
   output logic              prog_stb,
   output logic              swoff,
   output logic [DW-1:0]     cmd_rd
);
   localparam int PROG_BIT  = NBYTES + CMD_PROG_OFS;
   localparam int CLR_BIT   = NBYTES + CMD_CLR_OFS;
   localparam int SWOFF_BIT = NBYTES + CMD_SWOFF_OFS;

   logic [NBYTES-1:0] sel_q;
   logic              prog_q;
   logic              swoff_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q   <= '0;
         prog_q  <= 1'b0;
         swoff_q <= 1'b0;
      end else if (fault_i) begin
         sel_q   <= '0;
         prog_q  <= 1'b0;
         swoff_q <= 1'b0;
      end else begin
         if (prog_q && (!vpp_i || !otp_busy_i))
            prog_q <= 1'b0;
         if (wr_cmd) begin
            if (wr_data[CLR_BIT]) begin
               sel_q   <= '0;
               prog_q  <= 1'b0;
               swoff_q <= 1'b0;
            end else begin
               swoff_q <= wr_data[SWOFF_BIT];
               if (!locked) begin
                  sel_q <= wr_data[NBYTES-1:0];
                  if (wr_data[PROG_BIT] && vpp_i && !prog_q)
                     prog_q <= 1'b1;
               end
            end
         end
      end
   end

   assign prog_stb = prog_q && vpp_i && !otp_busy_i;
   assign sel      = sel_q;
   assign swoff    = swoff_q;

   always_comb begin
      cmd_rd            = '0;
      cmd_rd[NBYTES-1:0] = sel_q;
      cmd_rd[PROG_BIT]  = prog_q;
      cmd_rd[SWOFF_BIT] = swoff_q;
   end

   // R5
   fault_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_i |=> (cmd_rd == '0));

   // R7
   prog_needs_vpp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!prog_q && !vpp_i) |=> !cmd_rd[PROG_BIT]);

   // R6
   prog_wait_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_q && vpp_i && otp_busy_i && !fault_i && !(wr_cmd && wr_data[CLR_BIT]))
      |=> cmd_rd[PROG_BIT]);

   // R9
   soft_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cmd && wr_data[CLR_BIT]) |=> (cmd_rd == '0));

   // R8
   lock_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !fault_i && !(wr_cmd && wr_data[CLR_BIT])) |=> $stable(sel));
endmodule

// File: rtl/cfg_sel_mux.sv
module cfg_sel_mux #(
   parameter int NBYTES = 3,
   parameter int DW     = 8
) (
   input  logic [NBYTES*DW-1:0] work,
   input  logic [NBYTES*DW-1:0] otp,
   input  logic [NBYTES-1:0]    sel,
   output logic [NBYTES*DW-1:0] cfg
);
   for (genvar g = 0; g < NBYTES; g++) begin : g_byte
      assign cfg[g*DW +: DW] = sel[g] ? work[g*DW +: DW] : otp[g*DW +: DW];
   end
endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
   import cfgbank_pkg::*;
#(
   parameter int NBYTES   = 3,
   parameter int DW       = 8,
   parameter int AW       = 3,
   parameter int LOCK_BIT = 7,
   parameter bit LOCK_EN  = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fault_i,
   input  logic                 wr_en,
   input  logic [AW-1:0]        wr_addr,
   input  logic [DW-1:0]        wr_data,
   input  logic                 rd_en,
   input  logic [AW-1:0]        rd_addr,
   output logic [DW-1:0]        rd_data,
   input  logic                 vpp_i,
   input  logic                 otp_busy_i,
   output logic [NBYTES*DW-1:0] cfg_o,
   output logic                 swoff_o
);
   localparam int TOTAL = NBYTES * DW;
   localparam logic [AW-1:0] CMD_ADDR = AW'(NBYTES);

   if (NBYTES + CMD_EXTRA > DW) begin : g_bad_width
      $error("command fields do not fit in one data byte");
   end
   if ((1 << AW) <= NBYTES) begin : g_bad_addr
      $error("address width cannot reach the command register");
   end
   if (LOCK_BIT >= DW) begin : g_bad_lock
      $error("lock bit outside byte 0");
   end

   logic [TOTAL-1:0]  work_q;
   logic [TOTAL-1:0]  otp_img;
   logic [NBYTES-1:0] sel;
   logic              prog_stb;
   logic              locked;
   logic [DW-1:0]     cmd_rd;
   logic [DW-1:0]     rd_mux;
   logic [DW-1:0]     rd_q;
   logic              wr_cmd;

   if (LOCK_EN) begin : g_lock
      assign locked = otp_img[LOCK_BIT];
   end else begin : g_nolock
      assign locked = 1'b0;
   end

   assign wr_cmd = wr_en && (wr_addr == CMD_ADDR);

   for (genvar g = 0; g < NBYTES; g++) begin : g_work
      always_ff @(posedge clk) begin
         if (wr_en && (wr_addr == AW'(g)) && !locked)
            work_q[g*DW +: DW] <= wr_data;
      end
   end

   cfg_cmd_reg #(.NBYTES(NBYTES), .DW(DW)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .fault_i    (fault_i),
      .wr_cmd     (wr_cmd),
      .wr_data    (wr_data),
      .locked     (locked),
      .vpp_i      (vpp_i),
      .otp_busy_i (otp_busy_i),
      .sel        (sel),
      .prog_stb   (prog_stb),
      .swoff      (swoff_o),
      .cmd_rd     (cmd_rd)
   );

   cfg_otp_store #(.NBYTES(NBYTES), .DW(DW)) u_otp (
      .clk      (clk),
      .rst_n    (rst_n),
      .prog_stb (prog_stb),
      .wr_image (work_q),
      .rd_image (otp_img)
   );

   cfg_sel_mux #(.NBYTES(NBYTES), .DW(DW)) u_mux (
      .work (work_q),
      .otp  (otp_img),
      .sel  (sel),
      .cfg  (cfg_o)
   );

   always_comb begin
      rd_mux = '0;
      for (int i = 0; i < NBYTES; i++) begin
         if (rd_addr == AW'(i))
            rd_mux = sel[i] ? work_q[i*DW +: DW] : otp_img[i*DW +: DW];
      end
      if (rd_addr == CMD_ADDR)
         rd_mux = cmd_rd;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= '0;
      else if (rd_en)
         rd_q <= rd_mux;
   end

   assign rd_data = rd_q;

   // R4
   high_addr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (rd_addr > CMD_ADDR)) |=> (rd_data == '0));

   // R8
   lock_work_chk: assert property (@(posedge clk) disable iff (!rst_n)
      locked |=> $stable(work_q));
endmodule

// File: tb/tb_cfg_shadow_bank.sv
module tb_cfg_shadow_bank;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fault_i = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        rd_en = 1'b0;
   logic [2:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        vpp_i = 1'b0;
   logic        otp_busy_i = 1'b0;
   logic [23:0] cfg_o;
   logic        swoff_o;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [7:0] m_work [3];
   logic [7:0] m_otp  [3];
   logic [2:0] m_sel;

   always #10 clk = ~clk;

   cfg_shadow_bank dut (
      .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr),
      .rd_data(rd_data), .vpp_i(vpp_i), .otp_busy_i(otp_busy_i),
      .cfg_o(cfg_o), .swoff_o(swoff_o)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] v);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a;
      @(negedge clk);
      rd_en = 1'b0;
      v = rd_data;
   endtask

   function automatic logic [7:0] pick(input int b);
      return m_sel[b] ? m_work[b] : m_otp[b];
   endfunction

   task automatic check_cfg(input string req);
      for (int b = 0; b < 3; b++)
         chk(req, {24'h0, cfg_o[b*8 +: 8]}, {24'h0, pick(b)});
   endtask

   task automatic sweep();
      logic [7:0] v;
      for (int s = 0; s < 8; s++) begin
         wr(3'd3, 8'(s));
         m_sel = 3'(s);
         check_cfg("R3 sel sweep");
         for (int b = 0; b < 3; b++) begin
            rd(3'(b), v);
            chk("R2 readback", {24'h0, v}, {24'h0, pick(b)});
         end
      end
   endtask

   initial begin
      logic [7:0] v;
      for (int b = 0; b < 3; b++) m_otp[b] = 8'h00;
      m_sel = 3'b000;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      rd(3'd3, v);
      chk("R1 cmd", {24'h0, v}, 32'h0);
      chk("R1 swoff", {31'h0, swoff_o}, 32'h0);
      chk("R1 cfg", {8'h0, cfg_o}, 32'h0);

      // R2 working writes land regardless of select
      m_work[0] = 8'h35; m_work[1] = 8'hC6; m_work[2] = 8'h9E;
      for (int b = 0; b < 3; b++) wr(3'(b), m_work[b]);
      sweep();

      // R4 high addresses
      for (int a = 4; a < 8; a++) begin
         wr(3'(a), 8'hFF);
         rd(3'(a), v);
         chk("R4 high read", {24'h0, v}, 32'h0);
      end
      rd(3'd3, v);
      chk("R4 cmd untouched", {24'h0, v}, {29'h0, m_sel});
      check_cfg("R4 cfg untouched");
      chk("R4 swoff untouched", {31'h0, swoff_o}, 32'h0);

      // R7 program without vpp
      vpp_i = 1'b0;
      wr(3'd3, 8'h08);
      m_sel = 3'b000;
      rd(3'd3, v);
      chk("R7 prog bit", {24'h0, v}, 32'h0);
      check_cfg("R7 store blank");

      // R5 fault clears command
      wr(3'd3, 8'h07);
      m_sel = 3'b111;
      @(negedge clk); fault_i = 1'b1;
      @(negedge clk); fault_i = 1'b0;
      m_sel = 3'b000;
      rd(3'd3, v);
      chk("R5 cmd cleared", {24'h0, v}, 32'h0);
      check_cfg("R5 cfg fallback");
      wr(3'd3, 8'h07);
      m_sel = 3'b111;
      check_cfg("R5 working kept");

      // R6 program with busy stall
      vpp_i = 1'b1; otp_busy_i = 1'b1;
      wr(3'd3, 8'h08);
      m_sel = 3'b000;
      rd(3'd3, v);
      chk("R6 pending", {24'h0, v}, 32'h08);
      check_cfg("R6 store held while busy");
      @(negedge clk); otp_busy_i = 1'b0;
      @(negedge clk);
      for (int b = 0; b < 3; b++) m_otp[b] = m_work[b];
      vpp_i = 1'b0;
      rd(3'd3, v);
      chk("R6 prog cleared", {24'h0, v}, 32'h0);
      check_cfg("R6 store loaded");

      // R2 R3 with distinct copies
      m_work[0] = 8'h4B; m_work[1] = 8'h27; m_work[2] = 8'hE1;
      for (int b = 0; b < 3; b++) wr(3'(b), m_work[b]);
      sweep();

      // R9 switch-off and soft clear
      wr(3'd3, 8'h20);
      m_sel = 3'b000;
      chk("R9 swoff set", {31'h0, swoff_o}, 32'h1);
      rd(3'd3, v);
      chk("R9 cmd swoff", {24'h0, v}, 32'h20);
      wr(3'd3, 8'h37);
      chk("R9 swoff cleared", {31'h0, swoff_o}, 32'h0);
      rd(3'd3, v);
      chk("R9 cmd cleared", {24'h0, v}, 32'h0);

      // R8 program a locked image, selects left at 111
      m_work[0] = 8'h81;
      wr(3'd0, m_work[0]);
      vpp_i = 1'b1;
      wr(3'd3, 8'h0F);
      m_sel = 3'b111;
      @(negedge clk);
      for (int b = 0; b < 3; b++) m_otp[b] = m_work[b];
      m_work[0] = 8'h81;
      wr(3'd1, 8'h00);
      rd(3'd1, v);
      chk("R8 working write refused", {24'h0, v}, {24'h0, m_work[1]});
      wr(3'd3, 8'h00);
      rd(3'd3, v);
      chk("R8 select change refused", {24'h0, v}, 32'h07);
      wr(3'd3, 8'h28);
      rd(3'd3, v);
      chk("R8 swoff allowed, prog refused", {24'h0, v}, 32'h27);
      chk("R8 swoff out", {31'h0, swoff_o}, 32'h1);
      check_cfg("R8 cfg");
      wr(3'd3, 8'h10);
      m_sel = 3'b000;
      rd(3'd3, v);
      chk("R9 clear while locked", {24'h0, v}, 32'h0);
      wr(3'd3, 8'h07);
      rd(3'd3, v);
      chk("R8 select still refused", {24'h0, v}, 32'h0);
      check_cfg("R8 cfg store");
      vpp_i = 1'b0;

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule